// File: doc/BRIEF.md
# Fuse-Configured AND-OR Logic Array with Read-Back Lock

This block is the combinational heart of a small programmable logic part. A set of array inputs is offered to every product term in both polarities. Each product term is the AND of the literals whose fuse is left intact. Product terms are grouped into sum terms, and the group size differs from one sum term to the next. The remaining product terms are brought out on their own as control terms: one clock term and one reset term per register, one enable term per output cell, and a single preset term shared by all registers. The registers that use these terms sit outside this block.

The fuses are held in a configuration store that is loaded through a serial frame interface. A frame is shifted in and then executed. It can write one fuse, read one fuse back, or erase the whole array. A lock bit sits one address above the last fuse. Once the lock bit is set, every read-back reports the bit as programmed. Only the erase command clears the lock bit.

Top module: `pla_core`

## Requirements
- R1: Product term t is the AND of the literals whose fuse is 0 (intact). A fuse value of 1 (programmed) removes that literal. Literal 2*i is arr_in[i] and literal 2*i+1 is its complement. The fuse for literal l of term t is at address t*2*N_IN + l.
- R2: A product term that keeps every literal intact evaluates to 0. After an erase, therefore, every sum and control output is 0.
- R3: Sum term s is the OR of 4 + (s mod 5) consecutive product terms. The terms are placed in sum order, starting at term 0, so sum s never sees a term that belongs to its neighbour.
- R4: The control terms follow the last sum-term product term. First come the clock terms for registers 0..N_SUM-1, then the reset terms in the same order, then the enable terms for cells 0..N_CELL-1, and last the shared preset term.
- R5: While sh_en is high, one bit per cycle is shifted in, most significant bit first. The frame is op[1:0], then the address, then a data bit. A one-cycle cmd_go pulse executes the frame. The op values are 0 (no action), 1 (write the data bit), 2 (read) and 3 (erase).
- R6: With the lock bit clear, a read places the addressed fuse on rd_bit in the cycle after cmd_go.
- R7: Writing 1 to address FUSE_N sets the lock bit, shown on the secure output. The very next read then returns 1 at every address.
- R8: Erase clears every fuse to 0 and clears the lock bit.
- R9: Writing 0 to the lock address leaves the lock bit set. Only erase clears it.
- R10: Reset clears rd_bit and the frame shift register. It keeps the fuses and the lock bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arr_in | input | N_IN (12) | Array inputs: pins and register feedback |
| sh_en | input | 1 | Shift-enable for the serial frame |
| sh_din | input | 1 | Serial frame data, most significant bit first |
| cmd_go | input | 1 | Execute the shifted frame |
| rd_bit | output | 1 | Read-back result |
| secure | output | 1 | Lock bit state |
| sum_out | output | N_SUM (8) | Sum terms, two per output cell |
| clk_term | output | N_SUM (8) | Per-register clock product terms |
| rst_term | output | N_SUM (8) | Per-register reset product terms |
| oe_term | output | N_CELL (4) | Per-cell output-enable terms |
| preset_term | output | 1 | Shared preset product term |

## Verification
A fuse stored at the wrong place or with the wrong value shows up on one particular sum or control output. It appears combinationally in the same cycle as the input pattern that depends on that literal, so each programmed term is driven with input patterns that both meet and miss it. A fault in the lock or the erase path shows on rd_bit one cycle after the read frame executes. The bench therefore reads the same address before locking, after locking, after an attempted unlock, across a reset and after an erase.

// File: rtl/pla_pkg.sv
package pla_pkg;
  typedef enum logic [1:0] {OP_NOP = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2, OP_ERASE = 2'd3} op_e;

  // Product terms feeding sum s: varies 4..8 across sums.
  function automatic int terms_of(input int s);
    return 4 + (s % 5);
  endfunction

  // First product term of sum s.
  function automatic int base_of(input int s);
    int acc;
    acc = 0;
    for (int k = 0; k < s; k++) acc += terms_of(k);
    return acc;
  endfunction
endpackage

// File: rtl/fuse_store.sv
module fuse_store
  import pla_pkg::*;
#(
  parameter int FUSE_N = 64,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sh_en,
  input  logic              sh_din,
  input  logic              cmd_go,
  output logic [FUSE_N-1:0] fuse_o,
  output logic              secure_o,
  output logic              rd_bit_o
);
  localparam int FR_W = ADDR_W + 3;
  localparam logic [ADDR_W-1:0] SEC_ADDR = ADDR_W'(FUSE_N);

  logic [FR_W-1:0]   sr_q, sr_nxt;
  logic [FUSE_N-1:0] fuse_q;
  logic              sec_q, sec_nxt;
  logic              rd_q, rd_nxt;
  op_e               op;
  logic [ADDR_W-1:0] addr;
  logic              dbit;
  logic              in_range;

  assign op       = op_e'(sr_q[FR_W-1 -: 2]);
  assign addr     = sr_q[ADDR_W:1];
  assign dbit     = sr_q[0];
  assign in_range = (addr < SEC_ADDR);

  always_comb begin
    sr_nxt = sr_q;
    if (sh_en) sr_nxt = {sr_q[FR_W-2:0], sh_din};
  end

  always_comb begin
    sec_nxt = sec_q;
    rd_nxt  = rd_q;
    if (cmd_go) begin
      case (op)
        OP_WR:    if (addr == SEC_ADDR && dbit) sec_nxt = 1'b1;
        OP_ERASE: sec_nxt = 1'b0;
        OP_RD: begin
          if (sec_q)         rd_nxt = 1'b1;
          else if (in_range) rd_nxt = fuse_q[addr];
          else               rd_nxt = 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
      rd_q <= 1'b0;
    end else begin
      sr_q <= sr_nxt;
      rd_q <= rd_nxt;
    end
  end

  // Non-volatile state: not touched by reset.
  always_ff @(posedge clk) begin
    sec_q <= sec_nxt;
    if (cmd_go && op == OP_ERASE)
      fuse_q <= '0;
    else if (cmd_go && op == OP_WR && in_range)
      fuse_q[addr] <= dbit;
  end

  assign fuse_o   = fuse_q;
  assign secure_o = sec_q;
  assign rd_bit_o = rd_q;

  AST_LOCKED_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && op == OP_RD && sec_q) |=> rd_q); // R7
  AST_ERASE_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && op == OP_ERASE) |=> !sec_q); // R8
  AST_LOCK_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_q && !(cmd_go && op == OP_ERASE)) |=> sec_q); // R9
  AST_OPEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && op == OP_RD && !sec_q && in_range) |=> rd_q == $past(fuse_q[addr])); // R6
  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sh_en |=> $stable(sr_q)); // R5
endmodule

// File: rtl/and_plane.sv
module and_plane #(
  parameter int N_IN   = 12,
  parameter int N_TERM = 66
) (
  input  logic [N_IN-1:0]             arr_in,
  input  logic [N_TERM*2*N_IN-1:0]    fuse,
  output logic [N_TERM-1:0]           term
);
  localparam int LIT = 2 * N_IN;
  logic [LIT-1:0] lits;

  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lits[2*i]   = arr_in[i];
    assign lits[2*i+1] = ~arr_in[i];
  end

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    assign term[t] = &(fuse[t*LIT +: LIT] | lits);
  end
endmodule

// File: rtl/or_plane.sv
module or_plane
  import pla_pkg::*;
#(
  parameter int N_SUM  = 8,
  parameter int N_TERM = 45
) (
  input  logic [N_TERM-1:0] term,
  output logic [N_SUM-1:0]  sum
);
  for (genvar s = 0; s < N_SUM; s++) begin : g_sum
    localparam int B = base_of(s);
    localparam int W = terms_of(s);
    assign sum[s] = |term[B +: W];
  end
endmodule

// File: rtl/pla_core.sv
module pla_core
  import pla_pkg::*;
#(
  parameter int N_IN   = 12,
  parameter int N_CELL = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_IN-1:0]     arr_in,
  input  logic                sh_en,
  input  logic                sh_din,
  input  logic                cmd_go,
  output logic                rd_bit,
  output logic                secure,
  output logic [2*N_CELL-1:0] sum_out,
  output logic [2*N_CELL-1:0] clk_term,
  output logic [2*N_CELL-1:0] rst_term,
  output logic [N_CELL-1:0]   oe_term,
  output logic                preset_term
);
  localparam int N_SUM  = 2 * N_CELL;
  localparam int SUMT   = base_of(N_SUM);
  localparam int CLK_B  = SUMT;
  localparam int RST_B  = CLK_B + N_SUM;
  localparam int OE_B   = RST_B + N_SUM;
  localparam int PRE_T  = OE_B + N_CELL;
  localparam int N_TERM = PRE_T + 1;
  localparam int FUSE_N = N_TERM * 2 * N_IN;
  localparam int ADDR_W = $clog2(FUSE_N + 1);

  logic [1:0]        rst_sync;
  logic              rst_n_s;
  logic [FUSE_N-1:0] fuse;
  logic [N_TERM-1:0] term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  fuse_store #(.FUSE_N(FUSE_N), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n_s), .sh_en(sh_en), .sh_din(sh_din), .cmd_go(cmd_go),
    .fuse_o(fuse), .secure_o(secure), .rd_bit_o(rd_bit)
  );

  and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
    .arr_in(arr_in), .fuse(fuse), .term(term)
  );

  or_plane #(.N_SUM(N_SUM), .N_TERM(SUMT)) u_or (
    .term(term[SUMT-1:0]), .sum(sum_out)
  );

  assign clk_term    = term[CLK_B +: N_SUM];
  assign rst_term    = term[RST_B +: N_SUM];
  assign oe_term     = term[OE_B +: N_CELL];
  assign preset_term = term[PRE_T];

  AST_RESET_RD_CLEAR: assert property (@(posedge clk)
    !rst_n_s |=> !rd_bit); // R10
endmodule

// File: tb/sim_pla_core.sv
module sim_pla_core;
  localparam int N_IN = 12, N_CELL = 4, N_SUM = 8;
  localparam int LIT = 24;
  localparam int SUMT = 45;
  localparam int N_TERM = SUMT + 2*N_SUM + N_CELL + 1;  // 66
  localparam int FUSE_N = N_TERM * LIT;                  // 1584
  localparam int ADDR_W = 11;
  localparam int FR_W = ADDR_W + 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N_IN-1:0] arr_in = '0;
  logic sh_en = 1'b0, sh_din = 1'b0, cmd_go = 1'b0;
  logic rd_bit, secure, preset_term;
  logic [N_SUM-1:0] sum_out, clk_term, rst_term;
  logic [N_CELL-1:0] oe_term;

  int n_chk = 0, n_fail = 0;
  logic exp_q[$];
  string tag_q[$];
  event ev_rd;

  pla_core u0 (.clk(clk), .rst_n(rst_n), .arr_in(arr_in), .sh_en(sh_en), .sh_din(sh_din),
    .cmd_go(cmd_go), .rd_bit(rd_bit), .secure(secure), .sum_out(sum_out),
    .clk_term(clk_term), .rst_term(rst_term), .oe_term(oe_term), .preset_term(preset_term));

  always #10 clk = ~clk;

  function automatic int base_of(input int s);
    int acc = 0;
    for (int k = 0; k < s; k++) acc += 4 + (k % 5);
    return acc;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] op, input int addr, input logic d);
    logic [FR_W-1:0] f;
    f = {op, ADDR_W'(addr), d};
    for (int k = FR_W-1; k >= 0; k--) begin
      @(negedge clk); sh_en = 1'b1; sh_din = f[k];
    end
    @(negedge clk); sh_en = 1'b0; cmd_go = 1'b1;
    @(negedge clk); cmd_go = 1'b0;
  endtask

  task automatic rd(input int addr, input logic exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    send(2'd2, addr, 1'b0);
    -> ev_rd;
    #1;
  endtask

  // Program term t open everywhere except literals k0 and k1 (-1 = none).
  task automatic shape(input int t, input int k0, input int k1);
    for (int l = 0; l < LIT; l++)
      if (l != k0 && l != k1) send(2'd1, t*LIT + l, 1'b1);
  endtask

  // Scoreboard monitor
  initial forever begin
    @(ev_rd);
    begin
      logic e; string tg;
      e = exp_q.pop_front();
      tg = tag_q.pop_front();
      chk(rd_bit === e, tg, 32'(rd_bit), 32'(e));
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(rd_bit === 1'b0, "R10 reset rd_bit", 32'(rd_bit), 0);

    send(2'd3, 0, 1'b0); #1;
    chk(secure === 1'b0, "R8 erase lock", 32'(secure), 0);
    chk({sum_out, clk_term, rst_term, oe_term, preset_term} === '0, "R2 all intact zero",
        32'({sum_out, clk_term, rst_term, oe_term, preset_term}), 0);

    // R1/R3: sum 0 term 0 = in0 & ~in1
    shape(0, 0, 3);
    arr_in = 12'h001; #1;
    chk(sum_out === 8'h01, "R1 term met", 32'(sum_out), 32'h01);
    arr_in = 12'h003; #1;
    chk(sum_out === 8'h00, "R1 complement miss", 32'(sum_out), 0);
    arr_in = 12'h000; #1;
    chk(sum_out === 8'h00, "R1 true miss", 32'(sum_out), 0);

    // R3: last term of sum 4 (8-term group)
    shape(base_of(4) + 7, -1, -1); #1;
    chk(sum_out === 8'h10, "R3 group edge", 32'(sum_out), 32'h10);

    // R4: preset last, clock term reg 2 follows in5
    shape(PRE_T(), -1, -1);
    shape(SUMT + 2, 10, -1);
    arr_in = 12'h020; #1;
    chk(preset_term === 1'b1, "R4 preset", 32'(preset_term), 1);
    chk(clk_term === 8'h04, "R4 clk term on", 32'(clk_term), 32'h04);
    chk(rst_term === 8'h00 && oe_term === 4'h0, "R4 neighbours idle",
        32'({rst_term, oe_term}), 0);
    arr_in = 12'h000; #1;
    chk(clk_term === 8'h00, "R4 clk term off", 32'(clk_term), 0);

    // R5: no-op frame carrying a write pattern changes nothing
    send(2'd0, (SUMT+N_SUM)*LIT, 1'b1); #1;
    chk(rst_term === 8'h00, "R5 nop", 32'(rst_term), 0);

    rd(0, 1'b0, "R6 read intact");
    rd(1, 1'b1, "R6 read programmed");

    send(2'd1, FUSE_N, 1'b1); #1;
    chk(secure === 1'b1, "R7 lock set", 32'(secure), 1);
    rd(0, 1'b1, "R7 locked read");
    send(2'd1, FUSE_N, 1'b0);
    rd(3, 1'b1, "R9 lock held");

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    arr_in = 12'h001; #1;
    chk(secure === 1'b1 && rd_bit === 1'b0, "R10 reset keeps lock", 32'({secure, rd_bit}), 32'h2);
    chk(sum_out === 8'h11, "R10 reset keeps fuses", 32'(sum_out), 32'h11);

    send(2'd3, 0, 1'b0); #1;
    chk(secure === 1'b0, "R8 erase unlocks", 32'(secure), 0);
    chk(sum_out === 8'h00 && preset_term === 1'b0, "R8 erase clears", 32'({sum_out, preset_term}), 0);
    rd(1, 1'b0, "R8 read after erase");

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  function automatic int PRE_T();
    return N_TERM - 1;
  endfunction
endmodule